// File: doc/BRIEF.md
# Three-Channel Timer Host Register Port

This block is the register front end that a host uses to program and read back three interval-timer channels. Each channel has a data port at address 0, 1 or 2. The command port at address 3 accepts a command byte. A command can set how a channel's bytes are transferred. It can also freeze a channel's count, freeze several counts at once, or capture a status byte for readback. The counting engines are not part of this block. Their present counts and output levels come in on input buses. New reload values leave on a per-channel load strobe with a 16-bit value.

For each channel the block keeps the access mode (low byte only, high byte only, or low then high), the operating mode and the format flag. It also keeps a byte-order toggle and any frozen count or status byte that is waiting to be read. A frozen value stays until the host has read it out. Further freeze requests for that channel have no effect until then.

Top module: `timer_host_port`

## Requirements
- R1: After reset `rdata` is 0x00 and `load_stb` is all zero. Every channel is set to access code 11 (low then high), mode 000 and format 0.
- R2: Address 3 is the command port and addresses 0 to 2 are the data ports of channels 0 to 2. A read of address 3 returns 0x00.
- R3: The command byte is split as follows: bits 7-6 select the channel, bits 5-4 hold the access code, bits 3-1 hold the mode and bit 0 holds the format. A non-zero access code with channel 0 to 2 stores the access code, mode and format for that channel, and `chan_mode` shows the mode. The access codes are 01 for low only, 10 for high only and 11 for low then high.
- R4: Data writes produce a load. In access code 01 a write loads {0x00, byte}. In access code 10 a write loads {byte, 0x00}. In access code 11 the first write is held and the second write loads {second, first}. `load_stb` is high for the one cycle after the write that completes a load.
- R5: A read is acted on only in a cycle without a write. `rdata` updates at the clock edge that samples the read. When nothing is frozen, a read returns the live count: the low byte in access code 01, the high byte in access code 10, and low then high alternately in access code 11.
- R6: Access code 00 with channel 0 to 2 freezes that channel's count at the command edge. Reads return the frozen value until it has been fully read out. That takes one read in access codes 01 and 10, and two reads in access code 11.
- R7: A count-freeze request for a channel whose frozen count has not been fully read out is ignored.
- R8: Command nibble 1101 freezes the counts of every channel whose bit is set. Bit 1 selects channel 0, bit 2 selects channel 1 and bit 3 selects channel 2.
- R9: Command nibble 1110 captures a status byte for every channel selected with the same bits. The status byte is laid out as: bit 7 is the output level at capture, bit 6 is 0, bits 5-4 are the access code, bits 3-1 are the mode and bit 0 is the format. A new capture is ignored while a status byte is still unread.
- R10: If both a status byte and a frozen count are pending, the status byte is returned first.
- R11: Storing an access code resets the channel's byte-order toggle, so the next byte moved in access code 11 is the low byte.
- R12: Command nibbles 1100 and 1111 change no channel setting and freeze nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| addr | input | 2 | Port address (0-2 data, 3 command) |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Registered read byte |
| cnt_in | input | 48 | Live counts, channel n at bits 16n+15:16n |
| out_lvl | input | 3 | Output level of each channel |
| load_stb | output | 3 | One-cycle reload strobe per channel |
| load_val | output | 48 | Reload value per channel, same packing as cnt_in |
| chan_mode | output | 9 | Stored mode per channel, channel n at bits 3n+2:3n |

## Verification
A stuck or misaligned byte-order toggle shows up on the next data access as a swapped byte. A write then loads the wrong 16-bit value, or a read returns the high byte where the low byte was due. A frozen-count flag that never clears leaves later reads stuck on an old count. One that clears too early lets the live count leak into the second byte. Either fault is visible within two reads of the freeze. A status flag with the wrong priority returns a count byte in place of the status layout on the first read.

// File: rtl/timer_host_pkg.sv
package timer_host_pkg;
    localparam int CH_N   = 3;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int MODE_W = 3;
    localparam int ACC_W  = 2;

    localparam logic [ACC_W-1:0] ACC_LATCH = 2'b00;
    localparam logic [ACC_W-1:0] ACC_LO    = 2'b01;
    localparam logic [ACC_W-1:0] ACC_HI    = 2'b10;
    localparam logic [ACC_W-1:0] ACC_WORD  = 2'b11;

    localparam logic [3:0] NIB_MULTI_FREEZE = 4'b1101;
    localparam logic [3:0] NIB_STATUS_GRAB  = 4'b1110;

    typedef struct packed {
        logic [CH_N-1:0]   freeze;
        logic [CH_N-1:0]   grab_sts;
        logic [CH_N-1:0]   set_acc;
        logic [ACC_W-1:0]  acc;
        logic [MODE_W-1:0] mode;
        logic              fmt;
    } cmd_dec_t;
endpackage

// File: rtl/timer_cmd_decode.sv
module timer_cmd_decode
    import timer_host_pkg::*;
(
    input  logic              cmd_vld,
    input  logic [BYTE_W-1:0] cmd_byte,
    output cmd_dec_t          dec
);
    logic [3:0]       nib;
    logic [1:0]       chsel;
    logic [CH_N-1:0]  sel_bits;

    assign nib      = cmd_byte[7:4];
    assign chsel    = cmd_byte[7:6];
    assign sel_bits = cmd_byte[CH_N:1];

    always_comb begin
        dec          = '0;
        dec.acc      = cmd_byte[5:4];
        dec.mode     = cmd_byte[3:1];
        dec.fmt      = cmd_byte[0];
        if (cmd_vld) begin
            if (chsel != 2'd3) begin
                if (cmd_byte[5:4] == ACC_LATCH) dec.freeze[chsel]  = 1'b1;
                else                            dec.set_acc[chsel] = 1'b1;
            end else if (nib == NIB_MULTI_FREEZE) begin
                dec.freeze = sel_bits;
            end else if (nib == NIB_STATUS_GRAB) begin
                dec.grab_sts = sel_bits;
            end
        end
    end
endmodule

// File: rtl/timer_chan_port.sv
module timer_chan_port
    import timer_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_acc,
    input  logic [ACC_W-1:0]  acc_in,
    input  logic [MODE_W-1:0] mode_in,
    input  logic              fmt_in,
    input  logic              freeze,
    input  logic              grab_sts,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic [CNT_W-1:0]  cnt_live,
    input  logic              lvl,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              load_stb,
    output logic [CNT_W-1:0]  load_val,
    output logic [MODE_W-1:0] mode_out
);
    typedef struct packed {
        logic [ACC_W-1:0]  acc;
        logic [MODE_W-1:0] mode;
        logic              fmt;
        logic              hi_next;
        logic              cnt_v;
        logic [CNT_W-1:0]  cnt_f;
        logic              sts_v;
        logic [BYTE_W-1:0] sts_f;
        logic [BYTE_W-1:0] lo_hold;
        logic              ld;
        logic [CNT_W-1:0]  ld_val;
    } chan_st_t;

    chan_st_t st_q, st_d;
    logic [CNT_W-1:0] src;

    assign src = st_q.cnt_v ? st_q.cnt_f : cnt_live;

    always_comb begin
        if (st_q.sts_v)                                        rd_byte = st_q.sts_f;
        else if (st_q.acc == ACC_HI)                           rd_byte = src[CNT_W-1:BYTE_W];
        else if (st_q.acc == ACC_WORD && st_q.hi_next)         rd_byte = src[CNT_W-1:BYTE_W];
        else                                                   rd_byte = src[BYTE_W-1:0];
    end

    always_comb begin
        st_d    = st_q;
        st_d.ld = 1'b0;
        if (set_acc) begin
            st_d.acc     = acc_in;
            st_d.mode    = mode_in;
            st_d.fmt     = fmt_in;
            st_d.hi_next = 1'b0;
        end
        if (freeze && !st_q.cnt_v) begin
            st_d.cnt_v = 1'b1;
            st_d.cnt_f = cnt_live;
        end
        if (grab_sts && !st_q.sts_v) begin
            st_d.sts_v = 1'b1;
            st_d.sts_f = {lvl, 1'b0, st_q.acc, st_q.mode, st_q.fmt};
        end
        if (data_wr) begin
            unique case (st_q.acc)
                ACC_LO: begin
                    st_d.ld     = 1'b1;
                    st_d.ld_val = {{BYTE_W{1'b0}}, wbyte};
                end
                ACC_HI: begin
                    st_d.ld     = 1'b1;
                    st_d.ld_val = {wbyte, {BYTE_W{1'b0}}};
                end
                default: begin
                    if (!st_q.hi_next) begin
                        st_d.lo_hold = wbyte;
                        st_d.hi_next = 1'b1;
                    end else begin
                        st_d.ld      = 1'b1;
                        st_d.ld_val  = {wbyte, st_q.lo_hold};
                        st_d.hi_next = 1'b0;
                    end
                end
            endcase
        end
        if (data_rd) begin
            if (st_q.sts_v) begin
                st_d.sts_v = 1'b0;
            end else if (st_q.acc == ACC_WORD) begin
                st_d.hi_next = !st_q.hi_next;
                if (st_q.hi_next) st_d.cnt_v = 1'b0;
            end else begin
                st_d.cnt_v = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.acc <= ACC_WORD;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_stb = st_q.ld;
    assign load_val = st_q.ld_val;
    assign mode_out = st_q.mode;
endmodule

// File: rtl/timer_host_port.sv
module timer_host_port
    import timer_host_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [1:0]             addr,
    input  logic [BYTE_W-1:0]      wdata,
    output logic [BYTE_W-1:0]      rdata,
    input  logic [CH_N*CNT_W-1:0]  cnt_in,
    input  logic [CH_N-1:0]        out_lvl,
    output logic [CH_N-1:0]        load_stb,
    output logic [CH_N*CNT_W-1:0]  load_val,
    output logic [CH_N*MODE_W-1:0] chan_mode
);
    localparam logic [1:0] CMD_ADDR = 2'd3;

    typedef struct packed {
        logic [BYTE_W-1:0] rdata;
    } top_st_t;

    top_st_t          top_q, top_d;
    cmd_dec_t         dec;
    logic             rd_act;
    logic [BYTE_W-1:0] ch_byte [CH_N];

    assign rd_act = rd_en && !wr_en;

    timer_cmd_decode u_dec (
        .cmd_vld  (wr_en && addr == CMD_ADDR),
        .cmd_byte (wdata),
        .dec      (dec)
    );

    for (genvar i = 0; i < CH_N; i++) begin : g_ch
        timer_chan_port u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_acc  (dec.set_acc[i]),
            .acc_in   (dec.acc),
            .mode_in  (dec.mode),
            .fmt_in   (dec.fmt),
            .freeze   (dec.freeze[i]),
            .grab_sts (dec.grab_sts[i]),
            .data_wr  (wr_en && addr == 2'(i)),
            .data_rd  (rd_act && addr == 2'(i)),
            .wbyte    (wdata),
            .cnt_live (cnt_in[i*CNT_W +: CNT_W]),
            .lvl      (out_lvl[i]),
            .rd_byte  (ch_byte[i]),
            .load_stb (load_stb[i]),
            .load_val (load_val[i*CNT_W +: CNT_W]),
            .mode_out (chan_mode[i*MODE_W +: MODE_W])
        );
    end

    always_comb begin
        top_d = top_q;
        if (rd_act) begin
            if (addr == CMD_ADDR) top_d.rdata = '0;
            else                  top_d.rdata = ch_byte[addr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign rdata = top_q.rdata;
endmodule

// File: rtl/timer_host_port_chk.sv
module timer_host_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic [1:0] addr,
    input logic [7:0] rdata,
    input logic [2:0] load_stb
);
    // R4
    load_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_stb));

    // R4
    load_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr != 2'd3) |=> load_stb == 3'b000);

    // R5
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && !wr_en) |=> $stable(rdata));

    // R2
    cmd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == 2'd3) |=> rdata == 8'h00);
endmodule

bind timer_host_port timer_host_port_chk u_host_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .rdata    (rdata),
    .load_stb (load_stb)
);

// File: tb/timer_host_port_bench.sv
module timer_host_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [15:0] c0 = 16'h1234, c1 = '0, c2 = '0;
    logic [2:0]  out_lvl = 3'b001;
    logic [2:0]  load_stb;
    logic [47:0] load_val;
    logic [8:0]  chan_mode;
    int checks = 0, errors = 0;
    bit done = 0;

    always #5ns clk = ~clk;

    timer_host_port u_timer_host_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cnt_in({c2, c1, c0}), .out_lvl(out_lvl),
        .load_stb(load_stb), .load_val(load_val), .chan_mode(chan_mode)
    );

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic t_reset();
        logic [7:0] b;
        chk("R1 rdata", rdata, 8'h00);
        chk("R1 load_stb", load_stb, 3'b000);
        chk("R1 chan_mode", chan_mode, 9'h000);
        wr(3, 8'hE2);
        rd(0, b); chk("R1 R9 status ch0", b, 8'hB0);
        rd(0, b); chk("R5 live low", b, 8'h34);
        rd(0, b); chk("R5 live high", b, 8'h12);
        rd(3, b); chk("R2 cmd read", b, 8'h00);
    endtask

    task automatic t_write();
        wr(3, 8'h54); chk("R3 mode ch1", chan_mode[5:3], 3'd2);
        wr(1, 8'hAB);
        chk("R4 lo stb", load_stb, 3'b010); chk("R4 lo val", load_val[31:16], 16'h00AB);
        wr(3, 8'hA6); chk("R3 mode ch2", chan_mode[8:6], 3'd3);
        wr(2, 8'hCD);
        chk("R4 hi stb", load_stb, 3'b100); chk("R4 hi val", load_val[47:32], 16'hCD00);
        wr(3, 8'h30);
        wr(0, 8'h11); chk("R4 first byte held", load_stb, 3'b000);
        wr(0, 8'h22);
        chk("R4 word stb", load_stb, 3'b001); chk("R4 word val", load_val[15:0], 16'h2211);
    endtask

    task automatic t_live();
        logic [7:0] b;
        c1 = 16'h5678; c2 = 16'h9ABC;
        rd(1, b); chk("R5 lo only", b, 8'h78);
        rd(1, b); chk("R5 lo only again", b, 8'h78);
        rd(2, b); chk("R5 hi only", b, 8'h9A);
    endtask

    task automatic t_freeze();
        logic [7:0] b;
        c0 = 16'h4321;
        wr(3, 8'h00);
        c0 = 16'h8765;
        wr(3, 8'h00);
        rd(0, b); chk("R6 R7 frozen low", b, 8'h21);
        rd(0, b); chk("R6 R7 frozen high", b, 8'h43);
        rd(0, b); chk("R6 released low", b, 8'h65);
        rd(0, b); chk("R6 released high", b, 8'h87);
    endtask

    task automatic t_multi();
        logic [7:0] b;
        c1 = 16'h0F0E; c2 = 16'h1F1E;
        wr(3, 8'hDC);
        c1 = 16'hAAAA; c2 = 16'hBBBB; c0 = 16'h0102;
        rd(1, b); chk("R8 ch1 frozen", b, 8'h0E);
        rd(2, b); chk("R8 ch2 frozen", b, 8'h1F);
        rd(1, b); chk("R8 ch1 released", b, 8'hAA);
        rd(0, b); chk("R8 ch0 untouched", b, 8'h02);
        rd(0, b);
    endtask

    task automatic t_status_first();
        logic [7:0] b;
        c2 = 16'h3344; out_lvl[2] = 1'b0;
        wr(3, 8'hD8);
        wr(3, 8'hE8);
        out_lvl[2] = 1'b1;
        wr(3, 8'hE8);
        c2 = 16'h5566;
        rd(2, b); chk("R9 R10 status first", b, 8'h26);
        rd(2, b); chk("R10 count after status", b, 8'h33);
        rd(2, b); chk("R10 live after", b, 8'h55);
    endtask

    task automatic t_flip();
        logic [7:0] b;
        c0 = 16'hC3A5;
        rd(0, b); chk("R11 low before", b, 8'hA5);
        wr(3, 8'h30);
        rd(0, b); chk("R11 low after reset", b, 8'hA5);
        rd(0, b); chk("R11 high", b, 8'hC3);
    endtask

    task automatic t_unused();
        logic [7:0] b;
        rd(2, b);
        @(negedge clk); wr_en = 1'b1; rd_en = 1'b1; addr = 2'd3; wdata = 8'hC0;
        @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
        chk("R5 read ignored with write", rdata, {8'h00, b} & 48'hFF);
        wr(3, 8'hFE);
        chk("R12 modes kept", chan_mode, {3'd3, 3'd2, 3'd0});
        c1 = 16'h7E7D;
        rd(1, b); chk("R12 nothing frozen", b, 8'h7D);
        out_lvl[1] = 1'b0;
        wr(3, 8'hE4);
        rd(1, b); chk("R12 ch1 setting kept", b, 8'h14);
    endtask

    initial begin
        #2_000_000ns;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_live();
        t_freeze();
        t_multi();
        t_status_first();
        t_flip();
        t_unused();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule